// File: doc/BRIEF.md
# Serial Flash Read Command Engine

This block is the slave-side command logic of a serial memory that serves the plain read command. It runs on the chip's system clock and oversamples three serial pins: chip select (active low), serial clock and serial data in. Each sampled pin passes through a synchronizer, and edges of the serial clock are detected from the synchronized copy.

When chip select falls, the block collects an 8-bit instruction and then a 24-bit byte address. Both arrive most significant bit first. If the instruction is the read code and no program or erase cycle is busy, the block streams bytes from a memory array out on serial data out. The stream starts at the received address, steps the address after each byte, and wraps at the top of the array. It continues until chip select rises.

The array sits outside the block and is reached through a synchronous read port with one cycle of latency. The block fetches one byte ahead of the byte being shifted, so the stream has no gaps.

Top module: `sflash_read_engine`

## Requirements
- R1: After reset, and whenever chip select is high, `spi_miso_oe` is 0, `spi_miso` is 0 and no memory read is requested.
- R2: After chip select falls, the first 8 bits sampled on serial clock rising edges form the instruction, most significant bit first. The read instruction is 8'h03. The next 24 rising edges give the address, bit 23 first.
- R3: The first data bit is driven on the serial clock falling edge that follows the rising edge that captured address bit 0. From then on, one bit is driven per falling edge, each byte most significant bit first. `spi_miso_oe` is 0 until that first falling edge and is 1 from then until chip select rises. `spi_miso` changes only after a falling edge.
- R4: The first byte sent is the array byte at the received address, with no alignment restriction.
- R5: After each 8 bits, the next byte sent comes from the previous address plus one. The stream runs for as long as clocks arrive.
- R6: The array holds 2^ADDR_W bytes. Address bits above ADDR_W-1 are ignored. The byte after address 2^ADDR_W-1 comes from address 0, with no break in the stream.
- R7: A rising chip select ends the command at any bit, including mid-byte and in the same cycle as a serial clock falling edge. `spi_miso_oe` then returns to 0 and the next command starts from a fresh instruction.
- R8: If `busy` is high when the eighth instruction bit is captured, the command is rejected. No memory read is requested and `spi_miso_oe` stays 0 until chip select rises.
- R9: An instruction other than 8'h03 makes the block ignore the rest of the transaction: no memory read and `spi_miso_oe` stays 0 until chip select rises.
- R10: Each byte is fetched from the array before the previous byte's last bit is driven. With serial clock high and low phases each lasting at least 4 system clock cycles, the stream shows no gaps or repeated bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data in |
| busy | input | 1 | High while a program, erase or status-write cycle runs |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for serial data out; 0 means high impedance |
| mem_rd_en | output | 1 | Array read request |
| mem_rd_addr | output | ADDR_W | Array read address |
| mem_rd_data | input | 8 | Array read data, valid the cycle after the request |

## Verification
Two functions can land in the same system cycle: the release of chip select and a serial clock falling edge that would shift the next bit. The bench provokes this by driving chip select high and the serial clock low at the same instant, so both reach the synchronizer together. It judges the outcome in two ways: the output enable must be low a few cycles later, and the following command must return the correct bytes from its own start address. A second overlap, the byte-boundary reload that coincides with the address wrapping past the top of the array, is provoked by reads that start just below the top address.

// File: rtl/sflash_rd_pkg.sv
package sflash_rd_pkg;

    localparam int CMD_BITS  = 8;
    localparam int ADR_BITS  = 24;
    localparam int CNT_W     = $clog2(ADR_BITS);
    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CMD  = 3'd1,
        ST_ADDR = 3'd2,
        ST_DATA = 3'd3,
        ST_DROP = 3'd4
    } rd_state_e;

endpackage

// File: rtl/sflash_rd_sync.sv
module sflash_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_raw,
    input  logic sclk_raw,
    input  logic mosi_raw,
    output logic cs_s,
    output logic mosi_s,
    output logic sclk_rise,
    output logic sclk_fall
);
    localparam int LAST = STAGES - 1;
    // bit 0: chip select, bit 1: serial clock, bit 2: data in
    localparam logic [2:0] PIN_IDLE = 3'b001;

    logic [STAGES-1:0][2:0] pipe_d, pipe_q;
    logic                   prev_d, prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign pipe_d[g] = {mosi_raw, sclk_raw, cs_n_raw};
        end else begin : g_next
            assign pipe_d[g] = pipe_q[g-1];
        end
    end

    always_comb begin
        prev_d = pipe_q[LAST][1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{PIN_IDLE}};
            prev_q <= 1'b0;
        end else begin
            pipe_q <= pipe_d;
            prev_q <= prev_d;
        end
    end

    assign cs_s      = pipe_q[LAST][0];
    assign mosi_s    = pipe_q[LAST][2];
    assign sclk_rise = pipe_q[LAST][1] & ~prev_q;
    assign sclk_fall = ~pipe_q[LAST][1] & prev_q;

endmodule

// File: rtl/sflash_rd_ctrl.sv
module sflash_rd_ctrl
    import sflash_rd_pkg::*;
#(
    parameter int          ADDR_W = 10,
    parameter logic [7:0]  OPCODE = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              mosi_s,
    input  logic              sclk_rise,
    input  logic              busy,
    output rd_state_e         st,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr
);
    // Shift width: only as many bits as the opcode or the used address needs
    localparam int SH_W = (ADDR_W > CMD_BITS) ? ADDR_W : CMD_BITS;

    typedef struct packed {
        rd_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [SH_W-2:0]   sh;
        logic              start;
        logic [ADDR_W-1:0] start_addr;
    } ctrl_t;

    ctrl_t           d, q;
    logic [SH_W-1:0] shifted;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        shifted = {q.sh, mosi_s};
        if (cs_s) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    d.st  = ST_CMD;
                    d.cnt = '0;
                end
                ST_CMD: begin
                    if (sclk_rise) begin
                        d.sh  = shifted[SH_W-2:0];
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(CMD_BITS - 1)) begin
                            d.cnt = '0;
                            if (shifted[7:0] == OPCODE && !busy) begin
                                d.st = ST_ADDR;
                            end else begin
                                d.st = ST_DROP;
                            end
                        end
                    end
                end
                ST_ADDR: begin
                    if (sclk_rise) begin
                        d.sh  = shifted[SH_W-2:0];
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(ADR_BITS - 1)) begin
                            d.cnt        = '0;
                            d.st         = ST_DATA;
                            d.start      = 1'b1;
                            d.start_addr = shifted[ADDR_W-1:0];
                        end
                    end
                end
                ST_DATA, ST_DROP: begin
                    d.st = q.st;
                end
                default: d.st = ST_DROP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sh: '0, start: 1'b0, start_addr: '0};
        end else begin
            q <= d;
        end
    end

    assign st         = q.st;
    assign start      = q.start;
    assign start_addr = q.start_addr;

endmodule

// File: rtl/sflash_rd_tx.sv
module sflash_rd_tx
    import sflash_rd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  rd_state_e         st,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              sclk_fall,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              miso,
    output logic              miso_oe
);
    // Destination of a read return: the shifter itself or the look-ahead buffer
    localparam logic DST_SHIFT = 1'b0;
    localparam logic DST_AHEAD = 1'b1;

    typedef struct packed {
        logic                 rd_en;
        logic                 rd_dst;
        logic                 ret_vld;
        logic                 ret_dst;
        logic [ADDR_W-1:0]    fetch;
        logic [BYTE_W-1:0]    sh;
        logic [BYTE_W-1:0]    nxt;
        logic                 nxt_vld;
        logic [BIT_IDX_W-1:0] cnt;
        logic                 miso;
        logic                 miso_oe;
    } tx_t;

    tx_t  d, q;
    logic active;

    assign active = (st == ST_DATA) && !cs_s;

    always_comb begin
        d         = q;
        d.rd_en   = 1'b0;
        d.ret_vld = q.rd_en;
        d.ret_dst = q.rd_dst;
        if (!active) begin
            d.miso    = 1'b0;
            d.miso_oe = 1'b0;
            d.nxt_vld = 1'b0;
            d.cnt     = '0;
        end else begin
            if (start) begin
                d.rd_en  = 1'b1;
                d.rd_dst = DST_SHIFT;
                d.fetch  = start_addr;
                d.cnt    = '0;
            end
            if (q.ret_vld) begin
                if (q.ret_dst == DST_SHIFT) begin
                    d.sh     = mem_rd_data;
                    d.rd_en  = 1'b1;
                    d.rd_dst = DST_AHEAD;
                    d.fetch  = q.fetch + 1'b1;
                end else begin
                    d.nxt     = mem_rd_data;
                    d.nxt_vld = 1'b1;
                end
            end
            if (sclk_fall) begin
                d.miso    = q.sh[BYTE_W-1];
                d.miso_oe = 1'b1;
                d.sh      = {q.sh[BYTE_W-2:0], 1'b0};
                d.cnt     = q.cnt + 1'b1;
                if (q.cnt == BIT_IDX_W'(BYTE_W - 1)) begin
                    d.sh      = q.nxt;
                    d.nxt_vld = 1'b0;
                    d.rd_en   = 1'b1;
                    d.rd_dst  = DST_AHEAD;
                    d.fetch   = q.fetch + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_rd_en   = q.rd_en;
    assign mem_rd_addr = q.fetch;
    assign miso        = q.miso;
    assign miso_oe     = q.miso_oe;

endmodule

// File: rtl/sflash_read_engine.sv
module sflash_read_engine
    import sflash_rd_pkg::*;
#(
    parameter int         ADDR_W      = 10,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] OPCODE      = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              busy,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data
);
    logic              cs_s;
    logic              mosi_s;
    logic              sclk_rise;
    logic              sclk_fall;
    rd_state_e         st;
    logic              start;
    logic [ADDR_W-1:0] start_addr;

    sflash_rd_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_raw (spi_cs_n),
        .sclk_raw (spi_sclk),
        .mosi_raw (spi_mosi),
        .cs_s     (cs_s),
        .mosi_s   (mosi_s),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall)
    );

    sflash_rd_ctrl #(
        .ADDR_W(ADDR_W),
        .OPCODE(OPCODE)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .mosi_s    (mosi_s),
        .sclk_rise (sclk_rise),
        .busy      (busy),
        .st        (st),
        .start     (start),
        .start_addr(start_addr)
    );

    sflash_rd_tx #(
        .ADDR_W(ADDR_W)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (cs_s),
        .st         (st),
        .start      (start),
        .start_addr (start_addr),
        .sclk_fall  (sclk_fall),
        .mem_rd_data(mem_rd_data),
        .mem_rd_en  (mem_rd_en),
        .mem_rd_addr(mem_rd_addr),
        .miso       (spi_miso),
        .miso_oe    (spi_miso_oe)
    );

endmodule

// File: rtl/sflash_read_engine_chk.sv
module sflash_read_engine_chk
    import sflash_rd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input rd_state_e         st,
    input logic              sclk_rise,
    input logic              busy,
    input logic              miso,
    input logic              miso_oe,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr
);
    logic              have_q;
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            last_q <= '0;
        end else if (cs_s) begin
            have_q <= 1'b0;
        end else if (mem_rd_en) begin
            have_q <= 1'b1;
            last_q <= mem_rd_addr;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!miso_oe && !miso));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && have_q) |-> (mem_rd_addr == ADDR_W'(last_q + 1'b1)));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (!miso_oe && !mem_rd_en));

    p_busy_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CMD && sclk_rise && busy) |=> (st != ST_ADDR));

    p_drop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DROP) |=> (!miso_oe && !mem_rd_en));

endmodule

module sflash_rd_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       active,
    input logic       sclk_fall,
    input logic [2:0] bit_cnt,
    input logic       nxt_vld,
    input logic       miso,
    input logic       miso_oe
);
    p_drive_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe) && !$past(sclk_fall)) |-> $stable(miso));

    p_ahead_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sclk_fall && bit_cnt == 3'd7) |-> nxt_vld);

endmodule

bind sflash_read_engine sflash_read_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .st         (st),
    .sclk_rise  (sclk_rise),
    .busy       (busy),
    .miso       (spi_miso),
    .miso_oe    (spi_miso_oe),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_addr(mem_rd_addr)
);

bind sflash_rd_tx sflash_rd_tx_chk tx_chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .sclk_fall(sclk_fall),
    .bit_cnt  (q.cnt),
    .nxt_vld  (q.nxt_vld),
    .miso     (miso),
    .miso_oe  (miso_oe)
);

// File: tb/sflash_read_engine_tb_top.sv
`timescale 1ns/1ps
module sflash_read_engine_tb_top;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spi_cs_n = 1'b1;
    logic          spi_sclk = 1'b0;
    logic          spi_mosi = 1'b0;
    logic          busy = 1'b0;
    logic          spi_miso;
    logic          spi_miso_oe;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [7:0]    mem_rd_data;

    logic [7:0] mem [DEPTH];
    int unsigned rd_cnt = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sflash_read_engine #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .busy(busy), .spi_miso(spi_miso),
        .spi_miso_oe(spi_miso_oe), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
    );

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    end

    always @(posedge clk) if (mem_rd_en) rd_cnt <= rd_cnt + 1;

    function automatic logic [7:0] fill_val(int a);
        return 8'(a * 29 + 7) ^ 8'(a >> 3);
    endfunction

    function automatic logic [7:0] expect_byte(logic [23:0] start, int idx);
        return fill_val(int'((start[AW-1:0] + idx) % DEPTH));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    // op/addr: frame; nbits: data bits clocked; busy_v: busy level;
    // sync_end: release chip select together with a falling serial clock edge
    task automatic run_txn(input logic [7:0] op, input logic [23:0] addr,
                           input int nbits, input bit busy_v, input bit sync_end);
        logic [31:0] frame;
        logic [7:0]  got;
        bit          oe_ok;
        bit          any_oe;
        int unsigned rd0;
        bit          serve;
        serve = (op == 8'h03) && !busy_v;
        frame = {op, addr};
        @(negedge clk);
        busy = busy_v;
        spi_cs_n = 1'b0;
        rd0 = rd_cnt;
        half_wait();
        for (int i = 0; i < 32; i++) begin
            spi_mosi = frame[31-i];
            half_wait();
            spi_sclk = 1'b1;
            half_wait();
            if (i == 31) chk(spi_miso_oe == 1'b0, "R3 oe before data", int'(spi_miso_oe), 0);
            spi_sclk = 1'b0;
        end
        got = '0; oe_ok = 1'b1; any_oe = 1'b0;
        for (int k = 0; k < nbits; k++) begin
            half_wait();
            got = {got[6:0], spi_miso};
            if (spi_miso_oe) any_oe = 1'b1;
            if (!spi_miso_oe) oe_ok = 1'b0;
            if (serve && (k % 8) == 7) begin
                int b;
                logic [7:0] e;
                b = k / 8;
                e = expect_byte(addr, b);
                if (b == 0)
                    chk(oe_ok && got == e, "R2 R3 R4 first byte", int'(got), int'(e));
                else if (((addr[AW-1:0] + b) % DEPTH) == 0)
                    chk(oe_ok && got == e, "R6 wrap byte", int'(got), int'(e));
                else
                    chk(oe_ok && got == e, "R5 R10 stream byte", int'(got), int'(e));
                oe_ok = 1'b1;
            end
            spi_mosi = 1'($urandom);
            if (k == nbits - 1) break;
            spi_sclk = 1'b1;
            half_wait();
            spi_sclk = 1'b0;
        end
        if (sync_end) begin
            spi_sclk = 1'b1;
            half_wait();
            spi_sclk = 1'b0;
            spi_cs_n = 1'b1;
        end else begin
            spi_cs_n = 1'b1;
        end
        if (!serve) begin
            if (op != 8'h03)
                chk(!any_oe && rd_cnt == rd0, "R9 foreign opcode quiet", int'(rd_cnt - rd0), 0);
            else
                chk(!any_oe && rd_cnt == rd0, "R8 busy reject", int'(rd_cnt - rd0), 0);
        end
        half_wait();
        chk(spi_miso_oe == 1'b0, "R7 release", int'(spi_miso_oe), 0);
        busy = 1'b0;
        half_wait();
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int a = 0; a < DEPTH; a++) mem[a] = fill_val(a);
        repeat (5) @(negedge clk);
        chk(spi_miso_oe == 1'b0 && mem_rd_en == 1'b0, "R1 in reset", int'(spi_miso_oe), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(spi_miso_oe == 1'b0 && spi_miso == 1'b0 && mem_rd_en == 1'b0,
            "R1 after reset", int'({spi_miso_oe, spi_miso}), 0);

        run_txn(8'h03, 24'h000010, 32, 1'b0, 1'b0);
        run_txn(8'h03, 24'h0000FD, 40, 1'b0, 1'b0);
        run_txn(8'h03, 24'hABCD12, 16, 1'b0, 1'b0);
        run_txn(8'h0B, 24'h000020, 16, 1'b0, 1'b0);
        run_txn(8'h03, 24'h000020, 16, 1'b1, 1'b0);
        run_txn(8'h03, 24'h000020, 16, 1'b0, 1'b0);
        run_txn(8'h03, 24'h000040, 13, 1'b0, 1'b1);
        run_txn(8'h03, 24'h000041, 8, 1'b0, 1'b0);
        run_txn(8'h03, 24'h0000FF, 2056, 1'b0, 1'b0);

        for (int t = 0; t < 40; t++) begin
            int sel;
            logic [7:0] op;
            bit bz;
            sel = int'($urandom % 10);
            op = (sel == 0) ? 8'($urandom | 32'h1) : 8'h03;
            if (op == 8'h03 && sel == 0) op = 8'h05;
            bz = (sel == 1);
            run_txn(op, 24'($urandom), int'($urandom % 40) + 1, bz, 1'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule